// File: doc/BRIEF.md
# Paged Program Counter with High-Byte Holding Latch

This block keeps the 16-bit instruction address of a small 8-bit processor. The low byte of the address is visible as an ordinary data register, so it can be read, written and used in read-modify-write operations. The high byte has no address of its own. Software reaches it only through an 8-bit holding latch, and that latch is itself data-mapped.

The control decoder drives one strobe per kind of counter access: fetch, goto/call, long call, return, interrupt, low-byte read, low-byte write and latch write. Each access moves bytes between the counter, the latch, the opcode field, the data bus and the top of the return stack in its own way. All updates take effect at the next rising clock edge. When several strobes are active together, a fixed priority chooses one counter update and a separate rule chooses one latch update. The return stack, the ALU and the decoder are outside this block; it only receives their results.

Top module: `paged_pc`

## Requirements
- R1: While `rst` is high at a rising edge, the counter and the latch both become 0000h and 00h.
- R2: With only `fetch_i` active, the counter increments by one at the edge. It wraps from FFFFh to 0000h.
- R3: `pcl_rdata_o` always equals counter bits 7:0. A read of the low byte without a write in the same cycle copies counter bits 15:8 into the latch.
- R4: A low-byte write without a read loads the counter with {latch, `wdata_i`}. The latch used is the value from before the edge. No increment happens, even if `fetch_i` is active.
- R5: A read-modify-write (`pcl_rd_i` and `pcl_wr_i` together) loads the counter with {latch, `wdata_i`} and leaves the latch unchanged. Example: PC=03F0h and latch=03h with result 20h gives PC=0320h.
- R6: `lat_wr_i` loads the latch from `wdata_i` and does not move the counter.
- R7: A long call loads the counter with {latch, `opcode_i[7:0]`} and leaves the latch unchanged.
- R8: A goto/call loads counter bits 12:0 from `opcode_i[12:0]` and keeps bits 15:13. It also loads the latch with {old PC[15:13], `opcode_i[12:8]`}.
- R9: A return loads all 16 counter bits from `stack_top_i` and leaves the latch unchanged.
- R10: An interrupt loads the counter with the parameter `IRQ_VEC` (default 0008h) and leaves the latch unchanged.
- R11: Counter priority, highest first: interrupt, return, goto/call, long call, low-byte write, fetch increment. With no strobe active, the counter holds.
- R12: Latch priority, highest first: a goto/call that wins R11, then a latch write, then the copy on a read without a write. Otherwise the latch holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | Instruction fetched this cycle |
| jump_i | input | 1 | Goto or call |
| lcall_i | input | 1 | Long call |
| ret_i | input | 1 | Return of any kind |
| irq_i | input | 1 | Interrupt response |
| pcl_rd_i | input | 1 | Low byte is read |
| pcl_wr_i | input | 1 | Low byte is written |
| lat_wr_i | input | 1 | Holding latch is written |
| wdata_i | input | 8 | Data-bus write value or ALU result |
| opcode_i | input | 13 | Opcode address field |
| stack_top_i | input | 16 | Most recent stack entry |
| pc_o | output | 16 | Program counter |
| pcl_rdata_o | output | 8 | Low-byte read value |
| latch_o | output | 8 | Holding latch |

## Verification
The case that matters most is a low-byte access landing in the same cycle as a fetch or a control transfer. One example is a low-byte write with a fetch, where the write must suppress the increment. Another is a read together with a goto, where two different latch updates compete. The random phase sets every strobe independently, so such overlaps are common. Directed steps also stack interrupt, return and fetch in one cycle. A bench reference model applies the priorities of R11 and R12 and predicts both registers after every edge.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;
    localparam int PC_W   = 16;
    localparam int BYTE_W = 8;
    localparam int JMP_W  = 13;
    localparam int PAGE_W = PC_W - JMP_W;
    localparam int HI_W   = PC_W - BYTE_W;

    typedef enum logic [2:0] {
        ACT_HOLD, ACT_INC, ACT_PCLWR, ACT_LCALL, ACT_JUMP, ACT_RET, ACT_IRQ
    } pc_act_e;

    typedef enum logic [1:0] {
        LAT_HOLD, LAT_JUMP, LAT_WR, LAT_COPY
    } lat_act_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [HI_W-1:0] lat;
    } pc_state_t;

    typedef struct packed {
        logic fetch;
        logic jump;
        logic lcall;
        logic ret;
        logic irq;
        logic rd;
        logic wr;
        logic lat_wr;
    } pc_req_t;

    function automatic logic [PC_W-1:0] join_hl(input logic [HI_W-1:0] hi,
                                                input logic [BYTE_W-1:0] lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/paged_pc_arb.sv
module paged_pc_arb
    import paged_pc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pc_req_t  req,
    output pc_act_e  pc_act,
    output lat_act_e lat_act
);
    always_comb begin
        if (req.irq)        pc_act = ACT_IRQ;
        else if (req.ret)   pc_act = ACT_RET;
        else if (req.jump)  pc_act = ACT_JUMP;
        else if (req.lcall) pc_act = ACT_LCALL;
        else if (req.wr)    pc_act = ACT_PCLWR;
        else if (req.fetch) pc_act = ACT_INC;
        else                pc_act = ACT_HOLD;
    end

    always_comb begin
        if (pc_act == ACT_JUMP)      lat_act = LAT_JUMP;
        else if (req.lat_wr)         lat_act = LAT_WR;
        else if (req.rd && !req.wr)  lat_act = LAT_COPY;
        else                         lat_act = LAT_HOLD;
    end

    // R11: a low-byte write always blocks the increment
    p_wr_blocks_inc_r11: assert property (@(posedge clk) disable iff (rst)
        req.wr |-> pc_act != ACT_INC);
    // R12: a read-modify-write never copies into the latch
    p_rmw_no_copy_r12: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.wr) |-> lat_act != LAT_COPY);
endmodule

// File: rtl/paged_pc_next.sv
module paged_pc_next
    import paged_pc_pkg::*;
#(
    parameter logic [PC_W-1:0] IRQ_VEC = 16'h0008
) (
    input  pc_state_t          cur,
    input  pc_act_e            pc_act,
    input  lat_act_e           lat_act,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [JMP_W-1:0]   opcode,
    input  logic [PC_W-1:0]    stack_top,
    output pc_state_t          nxt
);
    logic [PAGE_W-1:0] page;
    assign page = cur.pc[PC_W-1:JMP_W];

    always_comb begin
        unique case (pc_act)
            ACT_IRQ:   nxt.pc = IRQ_VEC;
            ACT_RET:   nxt.pc = stack_top;
            ACT_JUMP:  nxt.pc = {page, opcode};
            ACT_LCALL: nxt.pc = join_hl(cur.lat, opcode[BYTE_W-1:0]);
            ACT_PCLWR: nxt.pc = join_hl(cur.lat, wdata);
            ACT_INC:   nxt.pc = cur.pc + 1'b1;
            default:   nxt.pc = cur.pc;
        endcase
    end

    always_comb begin
        unique case (lat_act)
            LAT_JUMP: nxt.lat = {page, opcode[JMP_W-1:BYTE_W]};
            LAT_WR:   nxt.lat = wdata;
            LAT_COPY: nxt.lat = cur.pc[PC_W-1:BYTE_W];
            default:  nxt.lat = cur.lat;
        endcase
    end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
    import paged_pc_pkg::*;
#(
    parameter logic [15:0] IRQ_VEC = 16'h0008
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_i,
    input  logic        jump_i,
    input  logic        lcall_i,
    input  logic        ret_i,
    input  logic        irq_i,
    input  logic        pcl_rd_i,
    input  logic        pcl_wr_i,
    input  logic        lat_wr_i,
    input  logic [7:0]  wdata_i,
    input  logic [12:0] opcode_i,
    input  logic [15:0] stack_top_i,
    output logic [15:0] pc_o,
    output logic [7:0]  pcl_rdata_o,
    output logic [7:0]  latch_o
);
    pc_req_t   req;
    pc_act_e   pc_act;
    lat_act_e  lat_act;
    pc_state_t cur, nxt;

    assign req = '{fetch: fetch_i, jump: jump_i, lcall: lcall_i, ret: ret_i,
                   irq: irq_i, rd: pcl_rd_i, wr: pcl_wr_i, lat_wr: lat_wr_i};

    paged_pc_arb u_arb (
        .clk(clk), .rst(rst), .req(req), .pc_act(pc_act), .lat_act(lat_act)
    );

    paged_pc_next #(.IRQ_VEC(IRQ_VEC)) u_next (
        .cur(cur), .pc_act(pc_act), .lat_act(lat_act), .wdata(wdata_i),
        .opcode(opcode_i), .stack_top(stack_top_i), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign pc_o        = cur.pc;
    assign latch_o     = cur.lat;
    assign pcl_rdata_o = cur.pc[BYTE_W-1:0];

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (pc_o == 16'h0000 && latch_o == 8'h00));
    p_inc_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_i && !irq_i && !ret_i && !jump_i && !lcall_i && !pcl_wr_i)
        |=> pc_o == $past(pc_o) + 16'd1);
    p_irq_vec_r10: assert property (@(posedge clk) disable iff (rst)
        irq_i |=> pc_o == IRQ_VEC);
    p_irq_keeps_lat_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_i && !lat_wr_i && !pcl_rd_i) |=> $stable(latch_o));
    p_ret_r9: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !irq_i) |=> pc_o == $past(stack_top_i));
    p_lcall_r7: assert property (@(posedge clk) disable iff (rst)
        (lcall_i && !irq_i && !ret_i && !jump_i)
        |=> pc_o == {$past(latch_o), $past(opcode_i[7:0])});
    p_jump_lat_r8: assert property (@(posedge clk) disable iff (rst)
        (jump_i && !irq_i && !ret_i)
        |=> latch_o == {$past(pc_o[15:13]), $past(opcode_i[12:8])});
    p_pclwr_r4: assert property (@(posedge clk) disable iff (rst)
        (pcl_wr_i && !irq_i && !ret_i && !jump_i && !lcall_i)
        |=> pc_o == {$past(latch_o), $past(wdata_i)});
    p_copy_r3: assert property (@(posedge clk) disable iff (rst)
        (pcl_rd_i && !pcl_wr_i && !lat_wr_i && !(jump_i && !irq_i && !ret_i))
        |=> latch_o == $past(pc_o[15:8]));
    p_latwr_r6: assert property (@(posedge clk) disable iff (rst)
        (lat_wr_i && !(jump_i && !irq_i && !ret_i)) |=> latch_o == $past(wdata_i));
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !(fetch_i || jump_i || lcall_i || ret_i || irq_i || pcl_wr_i) |=> $stable(pc_o));
endmodule

// File: tb/paged_pc_bench.sv
module paged_pc_bench;
    localparam logic [15:0] VEC = 16'h0008;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, fetch_i, jump_i, lcall_i, ret_i, irq_i, pcl_rd_i, pcl_wr_i, lat_wr_i;
    logic [7:0]  wdata_i;
    logic [12:0] opcode_i;
    logic [15:0] stack_top_i;
    logic [15:0] pc_o;
    logic [7:0]  pcl_rdata_o, latch_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_pc;
    logic [7:0]  m_lat;

    paged_pc #(.IRQ_VEC(VEC)) u_paged_pc (.*);

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of();
        if (irq_i && (ret_i || fetch_i || jump_i)) return "R11 irq-collision";
        if (irq_i)    return "R10 irq";
        if (ret_i)    return "R9 return";
        if (jump_i)   return "R8 goto";
        if (lcall_i)  return "R7 lcall";
        if (pcl_wr_i && pcl_rd_i) return "R5 rmw";
        if (pcl_wr_i) return "R4 pclwrite";
        if (lat_wr_i) return "R6 latchwrite";
        if (pcl_rd_i) return "R3 pclread";
        if (fetch_i)  return "R2 fetch";
        return "R11 idle";
    endfunction

    function automatic logic [15:0] ref_pc();
        if (irq_i)         return VEC;
        else if (ret_i)    return stack_top_i;
        else if (jump_i)   return {m_pc[15:13], opcode_i};
        else if (lcall_i)  return {m_lat, opcode_i[7:0]};
        else if (pcl_wr_i) return {m_lat, wdata_i};
        else if (fetch_i)  return m_pc + 16'd1;
        return m_pc;
    endfunction

    function automatic logic [7:0] ref_lat();
        if (jump_i && !irq_i && !ret_i) return {m_pc[15:13], opcode_i[12:8]};
        else if (lat_wr_i)              return wdata_i;
        else if (pcl_rd_i && !pcl_wr_i) return m_pc[15:8];
        return m_lat;
    endfunction

    task automatic idle_in();
        {fetch_i, jump_i, lcall_i, ret_i, irq_i, pcl_rd_i, pcl_wr_i, lat_wr_i} = '0;
    endtask

    // Inputs are set after a falling edge; the result is checked 1 ns after the rising edge.
    task automatic step();
        string t;
        logic [15:0] e_pc;
        logic [7:0]  e_lat;
        t = tag_of();
        chk("R3 rdata", {8'h00, pcl_rdata_o}, {8'h00, m_pc[7:0]});
        e_pc  = ref_pc();
        e_lat = ref_lat();
        @(posedge clk);
        #1;
        m_pc  = e_pc;
        m_lat = e_lat;
        chk({t, " pc"}, pc_o, m_pc);
        chk({t, " R12 latch"}, {8'h00, latch_o}, {8'h00, m_lat});
        @(negedge clk);
        idle_in();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_in();
        wdata_i = '0; opcode_i = '0; stack_top_i = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", pc_o, 16'h0000);
        chk("R1 reset latch", {8'h00, latch_o}, 16'h0000);
        rst = 1'b0;
        m_pc = '0; m_lat = '0;

        // R2 wrap: build FFFFh through the latch, then fetch
        lat_wr_i = 1; wdata_i = 8'hFF; step();
        pcl_wr_i = 1; wdata_i = 8'hFF; step();
        fetch_i = 1; step();
        // R5 in-page computed jump from the example
        lat_wr_i = 1; wdata_i = 8'h03; step();
        pcl_wr_i = 1; wdata_i = 8'hF0; fetch_i = 1; step();
        pcl_rd_i = 1; pcl_wr_i = 1; wdata_i = 8'hF0 + 8'h30; step();
        chk("R5 example", pc_o, 16'h0320);
        // R8 goto keeps the top page bits
        lat_wr_i = 1; wdata_i = 8'hE5; step();
        pcl_wr_i = 1; wdata_i = 8'h00; step();
        jump_i = 1; opcode_i = 13'h0123; pcl_rd_i = 1; lat_wr_i = 1; wdata_i = 8'h55; step();
        chk("R8 goto latch", {8'h00, latch_o}, 16'h00E1);
        // R3 read copy, then R7 long call
        pcl_rd_i = 1; fetch_i = 1; step();
        lcall_i = 1; opcode_i = 13'h1F9A; step();
        // R9, R10, R11 collisions
        ret_i = 1; stack_top_i = 16'hBEEF; fetch_i = 1; step();
        irq_i = 1; ret_i = 1; fetch_i = 1; jump_i = 1; step();
        step();

        for (int i = 0; i < 600; i++) begin
            fetch_i     = ($urandom() % 100) < 70;
            jump_i      = ($urandom() % 100) < 8;
            lcall_i     = ($urandom() % 100) < 8;
            ret_i       = ($urandom() % 100) < 6;
            irq_i       = ($urandom() % 100) < 4;
            pcl_rd_i    = ($urandom() % 100) < 15;
            pcl_wr_i    = ($urandom() % 100) < 12;
            lat_wr_i    = ($urandom() % 100) < 12;
            wdata_i     = 8'($urandom());
            opcode_i    = 13'($urandom());
            stack_top_i = 16'($urandom());
            step();
        end

        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset again pc", pc_o, 16'h0000);
        chk("R1 reset again latch", {8'h00, latch_o}, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule